// File: doc/BRIEF.md
# PLL Lock Loss Monitor

This block watches a set of lock indicators from clock managers or external PLLs, each asynchronous to the monitor clock. It reports a combined status that is high only while every monitored lock indicator is high. It also counts loss-of-lock events, so that unlocks too short for software polling to see are still recorded.

Software issues a one-cycle read strobe. One cycle later the block returns a pair: the lock status and the event count accumulated since the previous read. The same strobe starts a new counting interval. A healthy system reads back (locked, 0). A two-flop synchroniser on each lock input is part of the block.

Top module: `pll_lock_monitor`

## Requirements
- R1: `locked` is the AND of all `lock_raw` bits as sampled two rising edges earlier. That is the two-flop synchroniser latency: a change sampled at edge n shows on `locked` just after edge n+1.
- R2: A loss-of-lock event is a clock cycle in which at least one synchronised input goes from 1 to 0. It adds exactly one to the count, even when several inputs fall in the same cycle. The count takes the event one edge after `locked` shows the drop.
- R3: With two inputs, a fall on either input is an event, including a fall on one input while the other is already low.
- R4: An unlock that lasts a single clock cycle is counted.
- R5: A `rd_stb` high at edge n gives `rd_valid` high for exactly the cycle after edge n. In that cycle `rd_count` holds the count as it stood before edge n, and `rd_locked` holds the value `locked` had before edge n.
- R6: A read restarts the count at zero, so the next read reports only the events that arrived after it.
- R7: An event that is counted at the same edge as a read is not lost: it becomes the first event of the new interval.
- R8: The count is `CNT_W` bits wide (16 by default) and saturates at all-ones (65535 by default) instead of wrapping.
- R9: During and after reset, `locked` and `rd_valid` are 0 and the count is 0. The first lock after reset is not an event.
- R10: With all inputs held locked, repeated reads return `rd_locked` = 1 and `rd_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_raw | input | NUM_LOCK | Asynchronous lock indicators, 1 = locked |
| rd_stb | input | 1 | One-cycle read-and-clear request |
| locked | output | 1 | Combined synchronised lock status |
| rd_valid | output | 1 | Read response valid, one cycle |
| rd_locked | output | 1 | Lock status captured by the read |
| rd_count | output | CNT_W | Event count captured by the read |

## Verification
The assertions assume that `rd_stb` is a clean synchronous pulse. They also assume that an input level, once it reaches the second synchroniser flop, is stable. An unlock shorter than one clock period of the monitor clock cannot be guaranteed to be caught. The stimulus therefore changes `lock_raw` only on falling clock edges, and it holds every level for at least one full cycle. It alternates the inputs every cycle to reach saturation. It drops both inputs together, and it drops one input while the other is low. It also places reads on the same edge as a counted event.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int NUM_LOCK = 2,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_LOCK-1:0] lock_raw,
  input  logic                rd_stb,
  output logic                locked,
  output logic                rd_valid,
  output logic                rd_locked,
  output logic [CNT_W-1:0]    rd_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [NUM_LOCK-1:0] meta, stab, prev;
  logic [CNT_W-1:0]    cnt;
  logic                drop;

  assign drop   = |(prev & ~stab);
  assign locked = &stab;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      stab <= '0;
      prev <= '0;
    end else begin
      meta <= lock_raw;
      stab <= meta;
      prev <= stab;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      rd_valid  <= 1'b0;
      rd_locked <= 1'b0;
      rd_count  <= '0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) begin
        rd_locked <= locked;
        rd_count  <= cnt;
        cnt       <= drop ? CNT_ONE : '0;
      end else if (drop && cnt != CNT_MAX) begin
        cnt <= cnt + CNT_ONE;
      end
    end
  end

  // R1
  locked_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> &$past(lock_raw, 2));
  // R5
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid && rd_count == $past(cnt));
  // R6 R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> cnt <= CNT_ONE);
  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && cnt == CNT_MAX) |=> cnt == CNT_MAX);
  // R2
  no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> cnt >= $past(cnt));
  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> cnt == '0 && !rd_valid);
endmodule

// File: tb/pll_lock_monitor_test.sv
module pll_lock_monitor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] lock_raw = 2'b00;
  logic       rd_stb = 1'b0;
  logic       locked, rd_valid, rd_locked;
  logic [15:0] rd_count;

  always #2.5 clk = ~clk;

  pll_lock_monitor #(.NUM_LOCK(2), .CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .lock_raw(lock_raw), .rd_stb(rd_stb),
    .locked(locked), .rd_valid(rd_valid), .rd_locked(rd_locked), .rd_count(rd_count));

  int checks = 0, failures = 0, cycles = 0;
  string tag = "R9";
  logic [1:0] h1 = 0, h2 = 0, h3 = 0;
  int  cnt = 0;
  logic e_locked = 0, e_valid = 0, e_rlocked = 0;
  int  e_rcount = 0;
  bit  done = 0;

  task automatic chk(string t, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic ev, old_lock;
    cycles++;
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; cnt = 0; e_valid = 0;
    end else begin
      ev = |(h3 & ~h2);
      old_lock = &h2;
      e_valid = rd_stb;
      if (rd_stb) begin
        e_rcount = cnt; e_rlocked = old_lock; cnt = ev ? 1 : 0;
      end else if (ev && cnt < 65535) cnt = cnt + 1;
      h3 = h2; h2 = h1; h1 = lock_raw;
    end
    e_locked = &h2;
    #1;
    if (!done) begin
      chk(tag, "locked", int'(locked), int'(e_locked));
      chk(tag, "rd_valid", int'(rd_valid), int'(e_valid));
      if (e_valid) begin
        chk(tag, "rd_locked", int'(rd_locked), int'(e_rlocked));
        chk(tag, "rd_count", int'(rd_count), e_rcount);
      end
    end
  end

  task automatic step(logic [1:0] v, bit rd, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lock_raw = v; rd_stb = rd;
      rd = 0;
    end
  endtask

  task automatic expect_read(string t, int exp_cnt);
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0;
    #3;
    chk(t, "read count", int'(rd_count), exp_cnt);
  endtask

  initial begin
    // R9 reset state
    repeat (4) @(negedge clk);
    chk("R9", "reset locked", int'(locked), 0);
    chk("R9", "reset rd_valid", int'(rd_valid), 0);
    rst_n = 1;
    step(2'b11, 0, 6);
    expect_read("R9", 0);
    // R10 healthy steady reads
    tag = "R10";
    expect_read("R10", 0);
    expect_read("R10", 0);
    // R1 latency of one input unlocking
    tag = "R1";
    step(2'b01, 0, 5);
    step(2'b11, 0, 5);
    // R2 both drop together counts once, plus the R1 drop
    tag = "R2";
    step(2'b00, 0, 4);
    step(2'b11, 0, 4);
    expect_read("R2", 2);
    // R3 second input drops while first already low
    tag = "R3";
    step(2'b10, 0, 3);
    step(2'b00, 0, 3);
    step(2'b11, 0, 4);
    expect_read("R3", 2);
    // R4 single-cycle unlock pulses
    tag = "R4";
    step(2'b10, 0, 1); step(2'b11, 0, 3);
    step(2'b01, 0, 1); step(2'b11, 0, 3);
    expect_read("R4", 2);
    // R5 R6 read returns and clears
    tag = "R6";
    step(2'b01, 0, 1); step(2'b11, 0, 5);
    expect_read("R5", 1);
    expect_read("R6", 0);
    // R7 event on same edge as read: drop sampled at edge n counts at n+2
    tag = "R7";
    @(negedge clk); lock_raw = 2'b01;
    @(negedge clk);
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0; lock_raw = 2'b11;
    #3 chk("R7", "read before coincident event", int'(rd_count), 0);
    step(2'b11, 0, 4);
    expect_read("R7", 1);
    // R8 saturation
    tag = "R8";
    for (int i = 0; i < 65700; i++) begin
      @(negedge clk); lock_raw = 2'b00;
      @(negedge clk); lock_raw = 2'b11;
    end
    step(2'b11, 0, 4);
    expect_read("R8", 65535);
    expect_read("R8", 0);
    step(2'b11, 0, 3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 195000);
    done = 1;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=<195000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule